// File: doc/BRIEF.md
# Segmented LRU Replacement Controller

This block decides placement and replacement for a small fully associative tag store. It uses a two-segment recency policy. Every slot carries a valid flag, a tag, a segment flag and a recency rank. The segment flag marks the slot as probationary or protected. The rank orders the slot against the other slots in the same segment, with rank 0 as the most recently touched.

A fresh tag enters at the recent end of the probationary segment. A slot reaches the protected segment only when it is referenced a second time. When the protected segment is full, its oldest member is pushed back to the recent end of the probationary segment. That member then gets another chance before it can be replaced.

A requester presents a tag with a one-cycle strobe. On the following cycle the block reports:
- hit or miss;
- the slot that now holds the tag;
- the slot and old tag that were displaced, when a displacement happened.

Data storage, the memory side and the write policy belong to the surrounding logic.

Top module: `slru_ctrl`

## Requirements
- R1: After a synchronous reset every slot is invalid and `rsp_valid` is 0, so a tag that was stored before the reset misses afterwards.
- R2: A request taken on one rising edge produces `rsp_valid`=1 after that edge, for exactly one cycle. With no request, `rsp_valid` stays 0.
- R3: A request whose tag equals that of a valid slot reports `rsp_hit`=1, `rsp_evict`=0, and the matching slot number on `rsp_idx`.
- R4: A miss while any slot is invalid fills the lowest-numbered invalid slot, reports it on `rsp_idx`, and reports `rsp_evict`=0.
- R5: A miss with every slot valid replaces the oldest probationary slot. It reports `rsp_evict`=1 with that slot on both `rsp_victim_idx` and `rsp_idx`, and the displaced tag on `rsp_victim_tag`.
- R6: Each newly placed tag becomes the newest probationary slot. Among probationary slots that are never hit, replacement order is their placement order.
- R7: A hit on a probationary slot moves it into the protected segment. Protected slots are never replaced while the probationary segment holds any slot.
- R8: The protected segment never holds more than `PROT_MAX` slots. A promotion into a full protected segment moves its oldest slot to the newest probationary position.
- R9: Removing a hit slot from the probationary segment keeps the relative order of the remaining probationary slots.
- R10: When a replacement is needed and the probationary segment is empty, the oldest protected slot is replaced.
- R11: A hit on the newest protected slot leaves all segment flags and ranks unchanged.
- R12: A hit on a protected slot makes it the newest protected slot and ages the protected slots that were newer than it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_tag | input | TAG_W | Tag to look up |
| rsp_valid | output | 1 | Response present (cycle after request) |
| rsp_hit | output | 1 | 1 = tag was present |
| rsp_idx | output | $clog2(NUM_ENTRIES) | Slot now holding the requested tag |
| rsp_evict | output | 1 | 1 = a valid slot was displaced |
| rsp_victim_idx | output | $clog2(NUM_ENTRIES) | Displaced slot, 0 when `rsp_evict`=0 |
| rsp_victim_tag | output | TAG_W | Tag that was displaced, 0 when `rsp_evict`=0 |

## Verification
The main stream is a table-driven sequence of requests:
- Sequential fills separate lowest-free placement from any other choice.
- Second references to probationary slots, taken from both the ends and the middle of the list, separate promotion from simple reordering.
- A fifth promotion into a four-slot protected segment reveals whether demotion lands at the newest or the oldest probationary position. The demoted tag must survive three further misses.
- Repeated hits on the newest protected slot, followed by replacements, show that such hits leave the order unchanged.

A second instance, whose protected limit equals its slot count, is driven until every slot is protected. It shows that the fallback replaces the oldest protected slot.

// File: rtl/slru_pkg.sv
package slru_pkg;

    // Segment membership of one slot
    typedef enum logic {
        SEG_PROB = 1'b0,
        SEG_PROT = 1'b1
    } seg_e;

    // Update applied to the tag store in the cycle of a request
    typedef enum logic [1:0] {
        OP_NONE     = 2'd0,
        OP_HIT_PROT = 2'd1,
        OP_HIT_PROB = 2'd2,
        OP_INSERT   = 2'd3
    } slru_op_e;

    // Decision produced by the control path for one request
    typedef struct packed {
        slru_op_e op;
        logic     evict;
        logic     demote;
    } slru_ctl_t;

endpackage

// File: rtl/slru_match.sv
module slru_match #(
    parameter int N     = 8,
    parameter int TAG_W = 16,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]        key,
    output logic                    hit,
    output logic [IDX_W-1:0]        hit_idx,
    output logic                    has_free,
    output logic [IDX_W-1:0]        free_idx
);

    logic [N-1:0] match;

    // One comparator per slot
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        hit      = |match;
        hit_idx  = '0;
        has_free = ~&valid;
        free_idx = '0;
        // Scan downward so the lowest index wins
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/slru_census.sv
module slru_census #(
    parameter int N     = 8,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0]            seg,
    input  logic [N-1:0][IDX_W-1:0] rank,
    output logic [CNT_W-1:0]        prob_cnt,
    output logic [CNT_W-1:0]        prot_cnt,
    output logic [IDX_W-1:0]        prob_lru,
    output logic [IDX_W-1:0]        prot_lru
);
    import slru_pkg::*;

    always_comb begin
        prob_cnt = '0;
        prot_cnt = '0;
        for (int i = 0; i < N; i++) begin
            if (valid[i] && seg[i] == SEG_PROT) prot_cnt = prot_cnt + CNT_W'(1);
            if (valid[i] && seg[i] == SEG_PROB) prob_cnt = prob_cnt + CNT_W'(1);
        end
    end

    // Oldest member of a segment carries rank count-1
    always_comb begin
        prob_lru = '0;
        prot_lru = '0;
        for (int i = 0; i < N; i++) begin
            if (valid[i] && seg[i] == SEG_PROB &&
                CNT_W'(rank[i]) == prob_cnt - CNT_W'(1))
                prob_lru = IDX_W'(i);
            if (valid[i] && seg[i] == SEG_PROT &&
                CNT_W'(rank[i]) == prot_cnt - CNT_W'(1))
                prot_lru = IDX_W'(i);
        end
    end

endmodule

// File: rtl/slru_rerank.sv
module slru_rerank #(
    parameter int N     = 8,
    parameter int TAG_W = 16,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [N-1:0]            seg,
    input  logic [N-1:0][IDX_W-1:0] rank,
    input  slru_pkg::slru_ctl_t     ctl,
    input  logic [IDX_W-1:0]        tgt,
    input  logic [IDX_W-1:0]        tgt_rank,
    input  logic [IDX_W-1:0]        dem_idx,
    input  logic [TAG_W-1:0]        new_tag,
    output logic [N-1:0]            nxt_valid,
    output logic [N-1:0][TAG_W-1:0] nxt_tags,
    output logic [N-1:0]            nxt_seg,
    output logic [N-1:0][IDX_W-1:0] nxt_rank
);
    import slru_pkg::*;

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic is_tgt;
        logic is_dem;
        logic older;

        assign is_tgt = (tgt == IDX_W'(g));
        assign is_dem = ctl.demote && (dem_idx == IDX_W'(g));
        assign older  = rank[g] > tgt_rank;

        always_comb begin
            nxt_valid[g] = valid[g];
            nxt_tags[g]  = tags[g];
            nxt_seg[g]   = seg[g];
            nxt_rank[g]  = rank[g];
            case (ctl.op)
                OP_HIT_PROT: begin
                    // Move to newest protected; newer protected slots age by one
                    if (is_tgt) begin
                        nxt_rank[g] = '0;
                    end else if (valid[g] && seg[g] == SEG_PROT && rank[g] < tgt_rank) begin
                        nxt_rank[g] = rank[g] + IDX_W'(1);
                    end
                end
                OP_HIT_PROB: begin
                    if (is_tgt) begin
                        nxt_seg[g]  = SEG_PROT;
                        nxt_rank[g] = '0;
                    end else if (valid[g]) begin
                        if (is_dem) begin
                            nxt_seg[g]  = SEG_PROB;
                            nxt_rank[g] = '0;
                        end else if (seg[g] == SEG_PROT) begin
                            nxt_rank[g] = rank[g] + IDX_W'(1);
                        end else begin
                            // Close the gap left by the promoted slot,
                            // then make room for a demoted one
                            nxt_rank[g] = rank[g] - IDX_W'(older) + IDX_W'(ctl.demote);
                        end
                    end
                end
                OP_INSERT: begin
                    if (is_tgt) begin
                        nxt_valid[g] = 1'b1;
                        nxt_tags[g]  = new_tag;
                        nxt_seg[g]   = SEG_PROB;
                        nxt_rank[g]  = '0;
                    end else if (valid[g] && seg[g] == SEG_PROB) begin
                        nxt_rank[g] = rank[g] + IDX_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/slru_ctrl.sv
module slru_ctrl #(
    parameter int NUM_ENTRIES = 8,
    parameter int TAG_W       = 16,
    parameter int PROT_MAX    = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req_valid,
    input  logic [TAG_W-1:0]               req_tag,
    output logic                           rsp_valid,
    output logic                           rsp_hit,
    output logic [$clog2(NUM_ENTRIES)-1:0] rsp_idx,
    output logic                           rsp_evict,
    output logic [$clog2(NUM_ENTRIES)-1:0] rsp_victim_idx,
    output logic [TAG_W-1:0]               rsp_victim_tag
);
    import slru_pkg::*;

    localparam int N     = NUM_ENTRIES;
    localparam int IDX_W = $clog2(NUM_ENTRIES);
    localparam int CNT_W = $clog2(NUM_ENTRIES + 1);

    // Tag store state
    logic [N-1:0]            valid_q;
    logic [N-1:0][TAG_W-1:0] tag_q;
    logic [N-1:0]            seg_q;
    logic [N-1:0][IDX_W-1:0] rank_q;

    logic [N-1:0]            valid_d;
    logic [N-1:0][TAG_W-1:0] tag_d;
    logic [N-1:0]            seg_d;
    logic [N-1:0][IDX_W-1:0] rank_d;

    logic             hit, has_free;
    logic [IDX_W-1:0] hit_idx, free_idx;
    logic [CNT_W-1:0] prob_cnt, prot_cnt;
    logic [IDX_W-1:0] prob_lru, prot_lru;

    slru_ctl_t        ctl;
    logic [IDX_W-1:0] tgt, tgt_rank;

    slru_match #(.N(N), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
        .valid    (valid_q),
        .tags     (tag_q),
        .key      (req_tag),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .has_free (has_free),
        .free_idx (free_idx)
    );

    slru_census #(.N(N), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_census (
        .valid    (valid_q),
        .seg      (seg_q),
        .rank     (rank_q),
        .prob_cnt (prob_cnt),
        .prot_cnt (prot_cnt),
        .prob_lru (prob_lru),
        .prot_lru (prot_lru)
    );

    // Request decision
    always_comb begin
        ctl      = '{op: OP_NONE, evict: 1'b0, demote: 1'b0};
        tgt      = '0;
        tgt_rank = '0;
        if (req_valid) begin
            if (hit) begin
                tgt      = hit_idx;
                tgt_rank = rank_q[hit_idx];
                if (seg_q[hit_idx] == SEG_PROT) begin
                    ctl.op = OP_HIT_PROT;
                end else begin
                    ctl.op     = OP_HIT_PROB;
                    ctl.demote = (prot_cnt >= CNT_W'(PROT_MAX));
                end
            end else begin
                ctl.op = OP_INSERT;
                if (has_free) begin
                    tgt = free_idx;
                end else begin
                    ctl.evict = 1'b1;
                    tgt       = (prob_cnt != '0) ? prob_lru : prot_lru;
                end
            end
        end
    end

    slru_rerank #(.N(N), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_rerank (
        .valid     (valid_q),
        .tags      (tag_q),
        .seg       (seg_q),
        .rank      (rank_q),
        .ctl       (ctl),
        .tgt       (tgt),
        .tgt_rank  (tgt_rank),
        .dem_idx   (prot_lru),
        .new_tag   (req_tag),
        .nxt_valid (valid_d),
        .nxt_tags  (tag_d),
        .nxt_seg   (seg_d),
        .nxt_rank  (rank_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            tag_q   <= '0;
            seg_q   <= '0;
            rank_q  <= '0;
        end else begin
            valid_q <= valid_d;
            tag_q   <= tag_d;
            seg_q   <= seg_d;
            rank_q  <= rank_d;
        end
    end

    // Registered response
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_idx        <= '0;
            rsp_evict      <= 1'b0;
            rsp_victim_idx <= '0;
            rsp_victim_tag <= '0;
        end else begin
            rsp_valid      <= req_valid;
            rsp_hit        <= req_valid && hit;
            rsp_idx        <= tgt;
            rsp_evict      <= ctl.evict;
            rsp_victim_idx <= ctl.evict ? tgt : '0;
            rsp_victim_tag <= ctl.evict ? tag_q[tgt] : '0;
        end
    end

endmodule

// File: rtl/slru_ctrl_chk.sv
module slru_ctrl_chk #(
    parameter int N        = 8,
    parameter int IDX_W    = 3,
    parameter int PROT_MAX = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req_valid,
    input logic                    rsp_valid,
    input logic                    rsp_hit,
    input logic                    rsp_evict,
    input logic [IDX_W-1:0]        rsp_idx,
    input logic [IDX_W-1:0]        rsp_victim_idx,
    input logic [N-1:0]            valid_q,
    input logic [N-1:0]            seg_q,
    input logic [N-1:0][IDX_W-1:0] rank_q
);

    // Ranks within each segment form the set 0..count-1 with no repeats
    logic ranks_ok;
    always_comb begin
        int cnt_prot;
        int cnt_prob;
        ranks_ok = 1'b1;
        cnt_prot = 0;
        cnt_prob = 0;
        for (int i = 0; i < N; i++) begin
            if (valid_q[i] && seg_q[i]) cnt_prot++;
            if (valid_q[i] && !seg_q[i]) cnt_prob++;
        end
        for (int i = 0; i < N; i++) begin
            if (valid_q[i]) begin
                if (seg_q[i] && int'(rank_q[i]) >= cnt_prot) ranks_ok = 1'b0;
                if (!seg_q[i] && int'(rank_q[i]) >= cnt_prob) ranks_ok = 1'b0;
                for (int j = i + 1; j < N; j++) begin
                    if (valid_q[j] && seg_q[j] == seg_q[i] && rank_q[j] == rank_q[i])
                        ranks_ok = 1'b0;
                end
            end
        end
    end

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_slot_valid_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> valid_q[rsp_idx]);

    assert_evict_only_when_full_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_evict == (&$past(valid_q))));

    assert_evict_on_miss_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_evict |-> (rsp_valid && !rsp_hit && rsp_victim_idx == rsp_idx));

    assert_rank_contiguous_R6: assert property (@(posedge clk) disable iff (rst)
        ranks_ok);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(valid_q & seg_q) <= PROT_MAX);

endmodule

bind slru_ctrl slru_ctrl_chk #(.N(N), .IDX_W(IDX_W), .PROT_MAX(PROT_MAX)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_evict      (rsp_evict),
    .rsp_idx        (rsp_idx),
    .rsp_victim_idx (rsp_victim_idx),
    .valid_q        (valid_q),
    .seg_q          (seg_q),
    .rank_q         (rank_q)
);

// File: tb/test_slru_ctrl.sv
`timescale 1ns/1ps
module test_slru_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    // Main instance: 8 slots, protected limit 4
    logic        req_valid = 1'b0;
    logic [15:0] req_tag   = '0;
    logic        rsp_valid, rsp_hit, rsp_evict;
    logic [2:0]  rsp_idx, rsp_victim_idx;
    logic [15:0] rsp_victim_tag;

    slru_ctrl #(.NUM_ENTRIES(8), .TAG_W(16), .PROT_MAX(4)) i_slru_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
        .rsp_evict(rsp_evict), .rsp_victim_idx(rsp_victim_idx),
        .rsp_victim_tag(rsp_victim_tag)
    );

    // Second instance: 4 slots, protected limit equals slot count
    logic        f_req_valid = 1'b0;
    logic [15:0] f_req_tag   = '0;
    logic        f_rsp_valid, f_rsp_hit, f_rsp_evict;
    logic [1:0]  f_rsp_idx, f_rsp_victim_idx;
    logic [15:0] f_rsp_victim_tag;

    slru_ctrl #(.NUM_ENTRIES(4), .TAG_W(16), .PROT_MAX(4)) i_slru_ctrl_full (
        .clk(clk), .rst(rst), .req_valid(f_req_valid), .req_tag(f_req_tag),
        .rsp_valid(f_rsp_valid), .rsp_hit(f_rsp_hit), .rsp_idx(f_rsp_idx),
        .rsp_evict(f_rsp_evict), .rsp_victim_idx(f_rsp_victim_idx),
        .rsp_victim_tag(f_rsp_victim_tag)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [15:0] tag;
        logic        hit;
        logic [2:0]  idx;
        logic        evict;
        logic [2:0]  vidx;
        logic [15:0] vtag;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{16'h100, 1'b0, 3'd0, 1'b0, 3'd0, 16'h000, 8'd4},   // R4 fills
        '{16'h101, 1'b0, 3'd1, 1'b0, 3'd0, 16'h000, 8'd4},
        '{16'h102, 1'b0, 3'd2, 1'b0, 3'd0, 16'h000, 8'd4},
        '{16'h103, 1'b0, 3'd3, 1'b0, 3'd0, 16'h000, 8'd4},
        '{16'h104, 1'b0, 3'd4, 1'b0, 3'd0, 16'h000, 8'd4},
        '{16'h105, 1'b0, 3'd5, 1'b0, 3'd0, 16'h000, 8'd4},
        '{16'h106, 1'b0, 3'd6, 1'b0, 3'd0, 16'h000, 8'd4},
        '{16'h107, 1'b0, 3'd7, 1'b0, 3'd0, 16'h000, 8'd4},
        '{16'h100, 1'b1, 3'd0, 1'b0, 3'd0, 16'h000, 8'd7},   // R7 promote oldest
        '{16'h103, 1'b1, 3'd3, 1'b0, 3'd0, 16'h000, 8'd7},   // R3 hit middle
        '{16'h200, 1'b0, 3'd1, 1'b1, 3'd1, 16'h101, 8'd5},   // R5 oldest prob
        '{16'h201, 1'b0, 3'd2, 1'b1, 3'd2, 16'h102, 8'd5},
        '{16'h100, 1'b1, 3'd0, 1'b0, 3'd0, 16'h000, 8'd12},  // R12 protected hit
        '{16'h105, 1'b1, 3'd5, 1'b0, 3'd0, 16'h000, 8'd9},   // R9 prob middle
        '{16'h106, 1'b1, 3'd6, 1'b0, 3'd0, 16'h000, 8'd7},   // protected now full
        '{16'h107, 1'b1, 3'd7, 1'b0, 3'd0, 16'h000, 8'd8},   // R8 demotes 0x103
        '{16'h202, 1'b0, 3'd4, 1'b1, 3'd4, 16'h104, 8'd9},
        '{16'h203, 1'b0, 3'd1, 1'b1, 3'd1, 16'h200, 8'd5},
        '{16'h204, 1'b0, 3'd2, 1'b1, 3'd2, 16'h201, 8'd6},   // R6 placement order
        '{16'h205, 1'b0, 3'd3, 1'b1, 3'd3, 16'h103, 8'd8},   // demoted went newest
        '{16'h107, 1'b1, 3'd7, 1'b0, 3'd0, 16'h000, 8'd11},  // R11 newest protected
        '{16'h206, 1'b0, 3'd4, 1'b1, 3'd4, 16'h202, 8'd11}
    };

    // Caller is at a falling edge; returns at the next falling edge
    task automatic req_main(input logic [15:0] t, input logic exp_hit,
                            input logic [2:0] exp_idx, input logic exp_ev,
                            input logic [2:0] exp_vidx, input logic [15:0] exp_vtag,
                            input string rq);
        req_valid = 1'b1;
        req_tag   = t;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, "R2", "rsp_valid", 32'(rsp_valid), 32'h1);
        check(rsp_hit == exp_hit, rq, $sformatf("hit tag %0h", t), 32'(rsp_hit), 32'(exp_hit));
        check(rsp_idx == exp_idx, rq, $sformatf("idx tag %0h", t), 32'(rsp_idx), 32'(exp_idx));
        check(rsp_evict == exp_ev, rq, $sformatf("evict tag %0h", t), 32'(rsp_evict), 32'(exp_ev));
        check(rsp_victim_idx == exp_vidx, rq, "victim idx", 32'(rsp_victim_idx), 32'(exp_vidx));
        check(rsp_victim_tag == exp_vtag, rq, "victim tag", 32'(rsp_victim_tag), 32'(exp_vtag));
    endtask

    task automatic req_full(input logic [15:0] t, input logic exp_hit,
                            input logic [1:0] exp_idx, input logic exp_ev,
                            input logic [15:0] exp_vtag, input string rq);
        f_req_valid = 1'b1;
        f_req_tag   = t;
        @(negedge clk);
        f_req_valid = 1'b0;
        check(f_rsp_hit == exp_hit, rq, $sformatf("full hit tag %0h", t), 32'(f_rsp_hit), 32'(exp_hit));
        check(f_rsp_idx == exp_idx, rq, $sformatf("full idx tag %0h", t), 32'(f_rsp_idx), 32'(exp_idx));
        check(f_rsp_evict == exp_ev, rq, "full evict", 32'(f_rsp_evict), 32'(exp_ev));
        check(f_rsp_victim_tag == exp_vtag, rq, "full victim tag", 32'(f_rsp_victim_tag), 32'(exp_vtag));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            req_main(VECS[k].tag, VECS[k].hit, VECS[k].idx, VECS[k].evict,
                     VECS[k].vidx, VECS[k].vtag, $sformatf("R%0d", VECS[k].rq));
        end

        // R7: protected slot survived all replacements; R5: next victim is 0x203
        req_main(16'h100, 1'b1, 3'd0, 1'b0, 3'd0, 16'h000, "R7");
        req_main(16'h103, 1'b0, 3'd1, 1'b1, 3'd1, 16'h203, "R5");

        // R2: idle cycle gives no response
        @(negedge clk);
        check(rsp_valid == 1'b0, "R2", "rsp_valid idle", 32'(rsp_valid), 32'h0);

        // R1: reset clears contents
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        req_main(16'h100, 1'b0, 3'd0, 1'b0, 3'd0, 16'h000, "R1");

        // R10: every slot protected, then replacement
        req_full(16'h010, 1'b0, 2'd0, 1'b0, 16'h000, "R4");
        req_full(16'h011, 1'b0, 2'd1, 1'b0, 16'h000, "R4");
        req_full(16'h012, 1'b0, 2'd2, 1'b0, 16'h000, "R4");
        req_full(16'h013, 1'b0, 2'd3, 1'b0, 16'h000, "R4");
        req_full(16'h010, 1'b1, 2'd0, 1'b0, 16'h000, "R7");
        req_full(16'h011, 1'b1, 2'd1, 1'b0, 16'h000, "R7");
        req_full(16'h012, 1'b1, 2'd2, 1'b0, 16'h000, "R7");
        req_full(16'h013, 1'b1, 2'd3, 1'b0, 16'h000, "R7");
        req_full(16'h020, 1'b0, 2'd0, 1'b1, 16'h010, "R10");
        req_full(16'h021, 1'b0, 2'd0, 1'b1, 16'h020, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule